// File: doc/BRIEF.md
# Pipelined Transform Coefficient Quantizer

This block turns a 4x4 block of signed integer transform coefficients into quantized levels for a block-based video encoder. All sixteen lanes work in parallel. No divider is used: each lane takes the coefficient magnitude, multiplies it by a factor that depends on the quantization parameter and on the lane's position, adds a rounding offset, and shifts right. The sign of the input is then put back on the result.

A two-bit mode input selects one of three array types. These are an ordinary 4x4 residual block, a 4x4 luma DC block, and a 2x2 chroma DC block. In the 2x2 case only four lanes carry data. The other twelve lanes keep their registers frozen and drive zero. The pipeline is nine registers deep and accepts a new block on every clock. A valid bit moves through the pipeline together with the data.

The factor and offset lookups are combinational tables inside the block. The forward transform, rate control and entropy coding sit outside it.

Top module: `coef_quantizer`

## Requirements
- R1: A `qp_i` value above 51 is treated exactly as 51. Values 0 to 51 are used as given.
- R2: Let qbits = 15 + floor(QP/6). In residual mode a lane's sum is shifted right by qbits. In both DC modes it is shifted right by qbits+1.
- R3: The rounding offset is floor(2^qbits/3) when `intra_i` is 1 and floor(2^qbits/6) when it is 0. In both DC modes the offset is doubled.
- R4: In residual mode, lane l sits at row l/4 and column l%4. Its factor comes from QP%6 and from a position class. The classes are: row and column both even, row and column both odd, or one of each. The factor triples (even, odd, mixed) for QP%6 = 0..5 are 13107/5243/8066, 11916/4660/7490, 10082/4194/6554, 9362/3647/5825, 8192/3355/5243 and 7282/2893/4559.
- R5: `mode_i` encoding: 0 is residual, 1 is luma DC, 2 is chroma DC, and 3 behaves as residual. In both DC modes every lane uses the even/even factor.
- R6: A block sampled with `valid_i` high at a rising edge appears on `level_o` with `valid_o` high after the ninth rising edge, counting the sampling edge as the first. `valid_o` follows `valid_i` with this delay on every cycle, so a new block can enter on every cycle.
- R7: In chroma DC mode, lanes 0 to 3 carry the 2x2 block in raster order. Lanes 4 to 15 give zero on `level_o`, and their pipeline registers do not load data for that block.
- R8: Each level is the quantized magnitude with the input sign reapplied. A result of magnitude zero is 0 whatever the input sign, and an input of -32768 is handled as magnitude 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input block valid |
| mode_i | input | 2 | Array type (0 residual, 1 luma DC, 2 chroma DC, 3 residual) |
| qp_i | input | 6 | Quantization parameter |
| intra_i | input | 1 | Selects the intra rounding offset |
| coef_i | input | 256 | Sixteen signed 16-bit coefficients; lane l at bits l*16 +: 16 |
| valid_o | output | 1 | Output block valid |
| level_o | output | 256 | Sixteen signed 16-bit levels; lane l at bits l*16 +: 16 |

## Verification
Two functions can be active in the pipeline at the same time: the idle gating of lanes 4 to 15 for a chroma DC block, and the full sixteen-lane processing of a residual or luma block in a neighbouring stage. Each stage decides on its own whether to load, based on the block entering it. A block ahead of a chroma block must therefore still drain through the upper lanes, and a block behind it must refill those lanes.

The bench provokes this by feeding random modes back to back with `valid_i` mostly high, and by a directed run that alternates residual and chroma blocks. Every lane of every output block is compared against a reference model. A mistake in gating would show up as a stale or missing value in lanes 4 to 15 of the neighbouring block.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int QP_MAX     = 51;
  localparam int QBITS_BASE = 15;

  typedef enum logic [1:0] {
    MODE_RES = 2'd0,
    MODE_LDC = 2'd1,
    MODE_CDC = 2'd2,
    MODE_ALT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CLS_EVEN  = 2'd0,
    CLS_ODD   = 2'd1,
    CLS_MIXED = 2'd2
  } pos_cls_e;
endpackage

// File: rtl/cq_mf_lut.sv
module cq_mf_lut
  import cq_pkg::*;
#(
  parameter int MF_W = 14
) (
  input  logic [2:0]      qp_mod6_i,
  input  pos_cls_e        cls_i,
  output logic [MF_W-1:0] mf_o
);
  always_comb begin
    unique case ({qp_mod6_i, cls_i})
      {3'd0, CLS_EVEN}:  mf_o = MF_W'(13107);
      {3'd0, CLS_ODD}:   mf_o = MF_W'(5243);
      {3'd0, CLS_MIXED}: mf_o = MF_W'(8066);
      {3'd1, CLS_EVEN}:  mf_o = MF_W'(11916);
      {3'd1, CLS_ODD}:   mf_o = MF_W'(4660);
      {3'd1, CLS_MIXED}: mf_o = MF_W'(7490);
      {3'd2, CLS_EVEN}:  mf_o = MF_W'(10082);
      {3'd2, CLS_ODD}:   mf_o = MF_W'(4194);
      {3'd2, CLS_MIXED}: mf_o = MF_W'(6554);
      {3'd3, CLS_EVEN}:  mf_o = MF_W'(9362);
      {3'd3, CLS_ODD}:   mf_o = MF_W'(3647);
      {3'd3, CLS_MIXED}: mf_o = MF_W'(5825);
      {3'd4, CLS_EVEN}:  mf_o = MF_W'(8192);
      {3'd4, CLS_ODD}:   mf_o = MF_W'(3355);
      {3'd4, CLS_MIXED}: mf_o = MF_W'(5243);
      {3'd5, CLS_EVEN}:  mf_o = MF_W'(7282);
      {3'd5, CLS_ODD}:   mf_o = MF_W'(2893);
      {3'd5, CLS_MIXED}: mf_o = MF_W'(4559);
      default:           mf_o = '0;
    endcase
  end
endmodule

// File: rtl/cq_step.sv
module cq_step
  import cq_pkg::*;
#(
  parameter int QP_W  = 6,
  parameter int SH_W  = 5,
  parameter int ACC_W = 32
) (
  input  logic [QP_W-1:0]  qp_i,
  input  logic [1:0]       mode_i,
  input  logic             intra_i,
  output logic [2:0]       qp_mod6_o,
  output logic [SH_W-1:0]  shift_o,
  output logic [ACC_W-1:0] offset_o,
  output logic             dc_o,
  output logic             cdc_o
);
  logic [QP_W-1:0]  qp_c;
  logic [3:0]       qp_div6;
  logic [SH_W-1:0]  qbits;
  logic [SH_W-1:0]  third_exp;
  logic [ACC_W-1:0] base_off;

  // R1: clamp out-of-range QP
  assign qp_c      = (qp_i > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp_i;
  assign qp_div6   = 4'(qp_c / QP_W'(6));
  assign qp_mod6_o = 3'(qp_c % QP_W'(6));
  assign qbits     = SH_W'(QBITS_BASE) + SH_W'(qp_div6);

  // floor(2^q/6) == floor(2^(q-1)/3)
  assign third_exp = qbits - SH_W'(!intra_i);

  always_comb begin
    unique case (third_exp)
      SH_W'(14): base_off = ACC_W'(5461);
      SH_W'(15): base_off = ACC_W'(10922);
      SH_W'(16): base_off = ACC_W'(21845);
      SH_W'(17): base_off = ACC_W'(43690);
      SH_W'(18): base_off = ACC_W'(87381);
      SH_W'(19): base_off = ACC_W'(174762);
      SH_W'(20): base_off = ACC_W'(349525);
      SH_W'(21): base_off = ACC_W'(699050);
      SH_W'(22): base_off = ACC_W'(1398101);
      SH_W'(23): base_off = ACC_W'(2796202);
      default:   base_off = '0;
    endcase
  end

  assign dc_o     = (mode_i == MODE_LDC) || (mode_i == MODE_CDC);
  assign cdc_o    = (mode_i == MODE_CDC);
  assign shift_o  = qbits + SH_W'(dc_o);
  assign offset_o = dc_o ? (base_off << 1) : base_off;
endmodule

// File: rtl/cq_lane.sv
module cq_lane
  import cq_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int OUT_W      = 16,
  parameter int MF_W       = 14,
  parameter int ACC_W      = 32,
  parameter int SH_W       = 5,
  parameter int MUL_STAGES = 6,
  parameter int ROW        = 0,
  parameter int COL        = 0,
  localparam int LAT       = MUL_STAGES + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LAT-1:0]    en_i,      // bit k loads stage k+1
  input  logic              dc_i,
  input  logic [2:0]        qp_mod6_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [ACC_W-1:0]  offset_i,  // aligned to the add stage
  input  logic [SH_W-1:0]   shift_i,   // aligned to the shift stage
  input  logic              idle_i,
  output logic [OUT_W-1:0]  level_o
);
  localparam pos_cls_e POS_CLS =
      ((ROW % 2 == 0) && (COL % 2 == 0)) ? CLS_EVEN :
      ((ROW % 2 == 1) && (COL % 2 == 1)) ? CLS_ODD  : CLS_MIXED;

  pos_cls_e          cls;
  logic [MF_W-1:0]   mf;
  logic [COEF_W-1:0] mag_d;
  logic              sign_in;

  logic [COEF_W-1:0] mag_q;
  logic [MF_W-1:0]   mf_q;
  logic [LAT-1:0]    neg_q;
  logic [ACC_W-1:0]  prod_q [MUL_STAGES];
  logic [ACC_W-1:0]  sum_q;
  logic [ACC_W-1:0]  shifted;
  logic [OUT_W-1:0]  mag_out;
  logic [OUT_W-1:0]  lvl_q;

  assign cls     = dc_i ? CLS_EVEN : POS_CLS;
  assign sign_in = coef_i[COEF_W-1];
  assign mag_d   = sign_in ? (~coef_i + 1'b1) : coef_i;

  cq_mf_lut #(.MF_W(MF_W)) u_mf (
    .qp_mod6_i(qp_mod6_i),
    .cls_i    (cls),
    .mf_o     (mf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      mf_q  <= '0;
    end else if (en_i[0]) begin
      mag_q <= mag_d;
      mf_q  <= mf;
    end
  end

  for (genvar k = 0; k < LAT; k++) begin : g_neg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       neg_q[k] <= 1'b0;
      else if (en_i[k])  neg_q[k] <= (k == 0) ? sign_in : neg_q[(k == 0) ? 0 : k-1];
    end
  end

  for (genvar p = 0; p < MUL_STAGES; p++) begin : g_mul
    if (p == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        prod_q[p] <= '0;
        else if (en_i[1])   prod_q[p] <= ACC_W'(mag_q * mf_q);
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        prod_q[p] <= '0;
        else if (en_i[p+1]) prod_q[p] <= prod_q[p-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sum_q <= '0;
    else if (en_i[LAT-2])     sum_q <= prod_q[MUL_STAGES-1] + offset_i;
  end

  assign shifted = sum_q >> shift_i;
  assign mag_out = shifted[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lvl_q <= '0;
    else if (en_i[LAT-1])     lvl_q <= neg_q[LAT-2] ? (~mag_out + 1'b1) : mag_out;
  end

  assign level_o = idle_i ? '0 : lvl_q;

  // R7: a lane that is not loaded keeps its input stage
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[0] |=> ($stable(mag_q) && $stable(mf_q)));

  // R8: a nonzero level carries the sign that travelled with it
  p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != '0) |-> (lvl_q[OUT_W-1] == neg_q[LAT-1]));
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import cq_pkg::*;
#(
  parameter int DIM        = 4,
  parameter int CDC_LANES  = 4,
  parameter int COEF_W     = 16,
  parameter int OUT_W      = 16,
  parameter int MF_W       = 14,
  parameter int QP_W       = 6,
  parameter int SH_W       = 5,
  parameter int MUL_STAGES = 6,
  localparam int LANES     = DIM * DIM,
  localparam int ACC_W     = COEF_W + MF_W + 2,
  localparam int LAT       = MUL_STAGES + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              mode_i,
  input  logic [QP_W-1:0]         qp_i,
  input  logic                    intra_i,
  input  logic [LANES*COEF_W-1:0] coef_i,
  output logic                    valid_o,
  output logic [LANES*OUT_W-1:0]  level_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  typedef struct packed {
    logic             vld;
    logic             dc;
    logic             cdc;
    logic [SH_W-1:0]  shift;
    logic [ACC_W-1:0] offset;
  } ctrl_t;

  ctrl_t      ctrl_pipe [LAT+1];
  logic [2:0] qp_mod6;
  ctrl_t      ctrl_in;

  cq_step #(.QP_W(QP_W), .SH_W(SH_W), .ACC_W(ACC_W)) u_step (
    .qp_i     (qp_i),
    .mode_i   (mode_i),
    .intra_i  (intra_i),
    .qp_mod6_o(qp_mod6),
    .shift_o  (ctrl_in.shift),
    .offset_o (ctrl_in.offset),
    .dc_o     (ctrl_in.dc),
    .cdc_o    (ctrl_in.cdc)
  );
  assign ctrl_in.vld  = valid_i;
  assign ctrl_pipe[0] = ctrl_in;

  for (genvar s = 1; s <= LAT; s++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_pipe[s] <= '0;
      else         ctrl_pipe[s] <= ctrl_pipe[s-1];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit IDLE_OK = (l >= CDC_LANES);
    logic [LAT-1:0] en;

    always_comb begin
      for (int k = 0; k < LAT; k++)
        en[k] = ctrl_pipe[k].vld && !(IDLE_OK && ctrl_pipe[k].cdc);
    end

    cq_lane #(
      .COEF_W(COEF_W), .OUT_W(OUT_W), .MF_W(MF_W), .ACC_W(ACC_W), .SH_W(SH_W),
      .MUL_STAGES(MUL_STAGES), .ROW(l / DIM), .COL(l % DIM)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en),
      .dc_i     (ctrl_pipe[0].dc),
      .qp_mod6_i(qp_mod6),
      .coef_i   (coef_i[l*COEF_W +: COEF_W]),
      .offset_i (ctrl_pipe[LAT-2].offset),
      .shift_i  (ctrl_pipe[LAT-1].shift),
      .idle_i   (IDLE_OK && ctrl_pipe[LAT].cdc),
      .level_o  (level_o[l*OUT_W +: OUT_W])
    );
  end

  assign valid_o = ctrl_pipe[LAT].vld;

  logic [CNT_W-1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_rst_q <= '0;
    else if (since_rst_q != CNT_W'(LAT)) since_rst_q <= since_rst_q + 1'b1;
  end

  // R6: valid emerges a fixed LAT edges after it entered
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == CNT_W'(LAT)) |-> (valid_o == $past(valid_i, LAT)));

  // R2: shift stays within qbits range, one more in DC modes
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_pipe[1].vld |-> ((ctrl_pipe[1].shift >= SH_W'(QBITS_BASE)) &&
                          (ctrl_pipe[1].shift <= SH_W'(QBITS_BASE + 8 + 1))));

  // R3: rounding offset never reaches one quantizer step
  p_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_pipe[1].vld |-> (ctrl_pipe[1].offset < (ACC_W'(1) << ctrl_pipe[1].shift)));
endmodule

// File: tb/coef_quantizer_tb_top.sv
`timescale 1ns/1ps
module coef_quantizer_tb_top;
  localparam int LANES = 16;
  localparam int LAT   = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic [5:0]   qp_i = '0;
  logic         intra_i = 1'b0;
  logic [255:0] coef_i = '0;
  logic         valid_o;
  logic [255:0] level_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic         exp_vld [16];
  logic [255:0] exp_lvl [16];
  string        exp_tag [16];
  int           cur = 0;

  always #2.5 clk = ~clk;

  coef_quantizer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .qp_i(qp_i), .intra_i(intra_i), .coef_i(coef_i),
    .valid_o(valid_o), .level_o(level_o)
  );

  function automatic longint mf_of(int m, int cls);
    int t [6][3] = '{'{13107, 5243, 8066}, '{11916, 4660, 7490},
                     '{10082, 4194, 6554}, '{9362, 3647, 5825},
                     '{8192, 3355, 5243},  '{7282, 2893, 4559}};
    return t[m][cls];
  endfunction

  function automatic logic [15:0] ref_level(logic signed [15:0] c, int l,
                                            int mode, int qp, bit intra);
    int q, qb, cls, r, cc;
    longint f, mag, z;
    bit dc;
    q   = (qp > 51) ? 51 : qp;
    qb  = 15 + q / 6;
    f   = intra ? ((64'd1 << qb) / 3) : ((64'd1 << qb) / 6);
    if (mode == 2 && l >= 4) return 16'd0;
    dc  = (mode == 1) || (mode == 2);
    r   = l / 4;
    cc  = l % 4;
    cls = dc ? 0 : ((r % 2 == 0 && cc % 2 == 0) ? 0 : ((r % 2 == 1 && cc % 2 == 1) ? 1 : 2));
    mag = (c < 0) ? -longint'(c) : longint'(c);
    if (dc) z = (mag * mf_of(q % 6, cls) + 2 * f) >> (qb + 1);
    else    z = (mag * mf_of(q % 6, cls) + f) >> qb;
    return (c < 0) ? 16'(-z) : 16'(z);
  endfunction

  task automatic check_slot();
    int s = cur % 16;
    checks++;
    if (valid_o !== exp_vld[s]) begin
      errors++;
      $display("FAIL R6 cycle %0d valid_o act %b exp %b", cur, valid_o, exp_vld[s]);
    end
    if (exp_vld[s]) begin
      for (int l = 0; l < LANES; l++) begin
        checks++;
        if (level_o[l*16 +: 16] !== exp_lvl[s][l*16 +: 16]) begin
          errors++;
          $display("FAIL %s cycle %0d lane %0d act %0d exp %0d", exp_tag[s], cur, l,
                   $signed(level_o[l*16 +: 16]), $signed(exp_lvl[s][l*16 +: 16]));
        end
      end
    end
  endtask

  task automatic step(bit v, int mode, int qp, bit intra, logic [255:0] c, string tag);
    int s;
    @(negedge clk);
    check_slot();
    valid_i = v; mode_i = 2'(mode); qp_i = 6'(qp); intra_i = intra; coef_i = c;
    s = (cur + LAT) % 16;
    exp_vld[s] = v;
    exp_tag[s] = tag;
    for (int l = 0; l < LANES; l++)
      exp_lvl[s][l*16 +: 16] = ref_level(c[l*16 +: 16], l, mode, qp, intra);
    cur++;
  endtask

  function automatic logic [255:0] rand_coefs();
    logic [255:0] c;
    for (int l = 0; l < LANES; l++) begin
      case ($urandom % 4)
        0: c[l*16 +: 16] = 16'($urandom);
        1: c[l*16 +: 16] = 16'(int'($urandom % 401) - 200);
        2: c[l*16 +: 16] = 16'(int'($urandom % 21) - 10);
        default: c[l*16 +: 16] = ($urandom % 2) ? 16'h8000 : 16'h7fff;
      endcase
    end
    return c;
  endfunction

  function automatic logic [255:0] fill(logic [15:0] v);
    logic [255:0] c;
    for (int l = 0; l < LANES; l++) c[l*16 +: 16] = v;
    return c;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      exp_vld[i] = 1'b0; exp_lvl[i] = '0; exp_tag[i] = "R6";
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || level_o !== '0) begin
      errors++;
      $display("FAIL R6 reset state act %b/%h exp 0/0", valid_o, level_o);
    end

    // directed corners
    step(1, 0, 63, 1, rand_coefs(), "R1");
    step(1, 0, 51, 1, rand_coefs(), "R1");
    step(1, 0, 5, 0, fill(16'sd3000), "R2");
    step(1, 0, 6, 0, fill(16'sd3000), "R2");
    step(1, 0, 0, 1, fill(16'sd5), "R3");
    step(1, 0, 0, 0, fill(16'sd5), "R3");
    for (int q = 0; q < 6; q++) step(1, 0, q, 1, fill(16'sd1000), "R4");
    step(1, 1, 20, 0, rand_coefs(), "R5");
    step(1, 3, 20, 0, rand_coefs(), "R5");
    step(1, 2, 30, 1, rand_coefs(), "R7");
    step(1, 0, 30, 1, rand_coefs(), "R7");
    step(1, 2, 30, 1, fill(16'sh8000), "R7");
    step(0, 0, 0, 0, '0, "R6");
    step(1, 0, 12, 0, fill(16'sh8000), "R8");
    step(1, 0, 40, 0, fill(-16'sd3), "R8");
    step(1, 1, 0, 1, fill(16'sd0), "R8");
    for (int i = 0; i < 20; i++)
      step(1, (i % 2) ? 2 : 0, 25, i % 3 == 0, rand_coefs(), "R7");

    // constrained random
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, $urandom % 4, $urandom % 64, $urandom % 2,
           rand_coefs(), "R4");

    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 0, '0, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule